// File: doc/BRIEF.md
# Smartcard Reader Register and Trigger Unit

This block is the register-mapped shell around a smartcard character transceiver. A byte-wide bus with a 3-bit address reaches six registers. Through them software reads status, flushes the receive queue, sets the parity mode and trigger options, programs the card clock divisor, loads the elementary time unit (ETU) length, and exchanges data bytes. Received characters go into a 16-entry queue. A data read pops the oldest entry. A data write sends a one-cycle start pulse and the byte to the transceiver. The transceiver does the bit-level serialization and is outside this block.

The block divides the system clock into the card clock. The ETU is 11 bits wide and is assembled from two byte writes. It reaches the transceiver only after the second write completes. A trigger output marks byte boundaries for external instruments in three modes, which can be combined. Two modes give one-cycle pulses. The third, the hold mode, raises the trigger when a transmitted byte ends and keeps it high until the next reception or transmission starts.

Two small state machines carry the sequencing. The ETU loader has states ETU_TAKE_HIGH and ETU_TAKE_LOW. Every ETU write moves it from one state to the other. The trigger unit has states TRG_IDLE and TRG_HOLD. It goes from TRG_IDLE to TRG_HOLD when the hold mode is on and `tx_done` is high. It goes back from TRG_HOLD to TRG_IDLE on `rx_start` or `tx_start` when `tx_done` is not high in the same cycle.

Top module: `sc_reader_regs`

## Requirements
- R1: While reset is held, `etu_value` is 371, `parity_mode` is 0, `trigger`, `tx_start` and `card_clk` are 0. After reset the status read shows the queue empty and the parity flag clear.
- R2: Addresses: 0 status, 1 control, 2 config, 3 divisor, 4 ETU, 5 data. `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds until the next read. The status byte is {5'b0, empty, parity_error, tx_ready} (bit 0 is `tx_ready` as sampled, bit 1 is the parity flag, bit 2 means the queue is empty). A read of address 1, 2, 3 or 4 returns 0.
- R3: A received byte with `rx_parity_err` high sets the parity flag. A status write with bit 1 at 0 clears the flag. A status write with bit 1 at 1 leaves it as it is. When a set and a clear fall in the same cycle, the set wins.
- R4: A control write with bit 0 at 1 empties the receive queue. A byte that arrives in the same cycle is discarded as well.
- R5: The receive queue holds 16 bytes and returns them in arrival order. A byte that arrives while the queue is full is dropped.
- R6: A data read pops the oldest byte. A data read on an empty queue returns the byte that the last successful data read returned (0 if there was none).
- R7: A data write drives `tx_start` high for exactly the next cycle, with `tx_byte` equal to the written byte.
- R8: Config fields: bit 0 enables the transmit-end pulse, bit 1 the receive-start pulse, bit 2 the hold mode, and bits 4:3 select the parity mode (0 even, 1 odd, 2 forced 0, 3 forced 1). The parity mode is driven on `parity_mode` from the cycle after the write.
- R9: `card_clk` has a period of 2×(D+1) system cycles, where D is the divisor register. A divisor write restarts the count from zero.
- R10: An ETU write in state ETU_TAKE_HIGH stores `bus_wdata[2:0]` as bits 10:8 and leaves `etu_value` unchanged. The next ETU write stores `bus_wdata` as bits 7:0 and updates `etu_value` in the following cycle.
- R11: With the transmit-end pulse enabled, `trigger` is high for the one cycle after `tx_done`. With the pulse disabled and the hold mode off, `tx_done` leaves `trigger` low.
- R12: With the receive-start pulse enabled, `trigger` is high for the one cycle after `rx_start`.
- R13: With the hold mode on, `trigger` goes high in the cycle after `tx_done`. It stays high until the cycle after an `rx_start` or `tx_start` pulse, and goes low then unless a pulse mode raises it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| tx_start | output | 1 | One-cycle start pulse to the transceiver |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transceiver can accept a byte |
| tx_done | input | 1 | Pulse at the end of a transmitted byte |
| rx_start | input | 1 | Pulse at the start of a received byte |
| rx_valid | input | 1 | Received byte is valid |
| rx_byte | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity error on the received byte |
| parity_mode | output | 2 | Parity mode for the transceiver |
| etu_value | output | 11 | ETU length minus one |
| card_clk | output | 1 | Divided card clock |
| trigger | output | 1 | Trigger output |

## Verification
The queue is tested with three patterns:
- A short burst followed by drains, including a read past empty. This separates correct ordering from reuse of a stale byte.
- Eighteen bytes pushed into sixteen slots. This shows whether extra bytes are dropped or overwrite stored ones.
- A flush that coincides with an arriving byte. This tests the flush priority.

The trigger is tested with each mode alone, with the hold mode ended once by a reception and once by a transmission, and with all modes off. This shows apart the pulse and hold behaviour and the two ways the hold is released. The card clock is measured at two divisors (2 and 0) to confirm the 2×(D+1) scaling. The ETU is loaded with two different pairs to check the split of high and low bits and that the value is not updated after the first write.

// File: rtl/sc_reader_pkg.sv
`timescale 1ns/1ps
package sc_reader_pkg;

    // Register addresses on the byte bus
    localparam logic [2:0] ADDR_STATUS  = 3'd0;
    localparam logic [2:0] ADDR_CONTROL = 3'd1;
    localparam logic [2:0] ADDR_CONFIG  = 3'd2;
    localparam logic [2:0] ADDR_DIVISOR = 3'd3;
    localparam logic [2:0] ADDR_ETU     = 3'd4;
    localparam logic [2:0] ADDR_DATA    = 3'd5;

    // Field positions that software decodes
    localparam int STAT_READY_BIT  = 0;
    localparam int STAT_PERR_BIT   = 1;
    localparam int STAT_EMPTY_BIT  = 2;
    localparam int CTRL_FLUSH_BIT  = 0;
    localparam int CFG_W           = 5;

    // Configuration word, bit 0 at the bottom of the packed struct
    typedef struct packed {
        logic [1:0] parity_mode;   // bits 4:3
        logic       trig_hold;     // bit 2
        logic       trig_rx;       // bit 1
        logic       trig_tx;       // bit 0
    } cfg_t;

    typedef enum logic {
        ETU_TAKE_HIGH,
        ETU_TAKE_LOW
    } etu_state_e;

    typedef enum logic {
        TRG_IDLE,
        TRG_HOLD
    } trg_state_e;

endpackage

// File: rtl/sc_rx_fifo.sv
`timescale 1ns/1ps
module sc_rx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    level
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_LVL  = CW'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (level == '0);
    assign full    = (level == FULL_LVL);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = slots[rd_ptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            level <= level + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= din;
    end

endmodule

// File: rtl/sc_card_clk_div.sv
`timescale 1ns/1ps
module sc_card_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_value,
    input  logic             reload,
    output logic             card_clk
);

    logic [DIV_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            card_clk <= 1'b0;
        end else if (reload) begin
            count <= '0;
        end else if (count == div_value) begin
            count    <= '0;
            card_clk <= ~card_clk;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/sc_etu_loader.sv
`timescale 1ns/1ps
module sc_etu_loader
    import sc_reader_pkg::*;
#(
    parameter int ETU_W     = 11,
    parameter int BUS_W     = 8,
    parameter int ETU_RESET = 371,
    localparam int HI_W = ETU_W - BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    output logic [ETU_W-1:0] etu_value
);

    etu_state_e      state_q;
    etu_state_e      state_d;
    logic [HI_W-1:0] high_part;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ETU_TAKE_HIGH: if (wr) state_d = ETU_TAKE_LOW;
            ETU_TAKE_LOW:  if (wr) state_d = ETU_TAKE_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ETU_TAKE_HIGH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_part <= '0;
            etu_value <= ETU_W'(ETU_RESET);
        end else if (wr) begin
            unique case (state_q)
                ETU_TAKE_HIGH: high_part <= wdata[HI_W-1:0];
                ETU_TAKE_LOW:  etu_value <= {high_part, wdata};
            endcase
        end
    end

endmodule

// File: rtl/sc_trigger_unit.sv
`timescale 1ns/1ps
module sc_trigger_unit
    import sc_reader_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_tx_pulse,
    input  logic en_rx_pulse,
    input  logic en_hold,
    input  logic tx_done,
    input  logic rx_start,
    input  logic tx_begin,
    output logic trigger
);

    trg_state_e state_q;
    trg_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_IDLE: begin
                if (en_hold && tx_done) state_d = TRG_HOLD;
            end
            TRG_HOLD: begin
                if (en_hold && tx_done)        state_d = TRG_HOLD;
                else if (rx_start || tx_begin) state_d = TRG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trigger <= 1'b0;
        end else begin
            trigger <= (tx_done && en_tx_pulse)
                     || (rx_start && en_rx_pulse)
                     || (state_d == TRG_HOLD);
        end
    end

endmodule

// File: rtl/sc_reader_regs.sv
`timescale 1ns/1ps
module sc_reader_regs
    import sc_reader_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int ETU_W      = 11,
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_RESET  = 0,
    parameter int ETU_RESET  = 371,
    localparam int BUS_W = 8,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             tx_start,
    output logic [BUS_W-1:0] tx_byte,
    input  logic             tx_ready,
    input  logic             tx_done,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic [BUS_W-1:0] rx_byte,
    input  logic             rx_parity_err,
    output logic [1:0]       parity_mode,
    output logic [ETU_W-1:0] etu_value,
    output logic             card_clk,
    output logic             trigger
);

    // Write strobes per register
    logic wr_status, wr_control, wr_config, wr_divisor, wr_etu, wr_data;
    logic rd_data;

    assign wr_status  = bus_wr && (bus_addr == ADDR_STATUS);
    assign wr_control = bus_wr && (bus_addr == ADDR_CONTROL);
    assign wr_config  = bus_wr && (bus_addr == ADDR_CONFIG);
    assign wr_divisor = bus_wr && (bus_addr == ADDR_DIVISOR);
    assign wr_etu     = bus_wr && (bus_addr == ADDR_ETU);
    assign wr_data    = bus_wr && (bus_addr == ADDR_DATA);
    assign rd_data    = bus_rd && (bus_addr == ADDR_DATA);

    // Configuration and divisor registers
    cfg_t             cfg_q;
    logic [DIV_W-1:0] divisor_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            divisor_q <= DIV_W'(DIV_RESET);
        end else begin
            if (wr_config)  cfg_q     <= cfg_t'(bus_wdata[CFG_W-1:0]);
            if (wr_divisor) divisor_q <= bus_wdata[DIV_W-1:0];
        end
    end

    assign parity_mode = cfg_q.parity_mode;

    // Parity error flag: set by the transceiver, cleared by writing zero
    logic parity_flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_flag <= 1'b0;
        end else if (rx_valid && rx_parity_err) begin
            parity_flag <= 1'b1;
        end else if (wr_status && !bus_wdata[STAT_PERR_BIT]) begin
            parity_flag <= 1'b0;
        end
    end

    // Receive queue
    logic [BUS_W-1:0] fifo_dout;
    logic             fifo_empty;
    logic             fifo_full;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_flush;

    assign fifo_flush = wr_control && bus_wdata[CTRL_FLUSH_BIT];

    sc_rx_fifo #(
        .WIDTH (BUS_W),
        .DEPTH (FIFO_DEPTH)
    ) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .din   (rx_byte),
        .pop   (rd_data),
        .flush (fifo_flush),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .level (fifo_level)
    );

    // Read path: registered, last popped byte kept for empty reads
    logic [BUS_W-1:0] last_popped;
    logic [BUS_W-1:0] status_byte;

    always_comb begin
        status_byte                 = '0;
        status_byte[STAT_READY_BIT] = tx_ready;
        status_byte[STAT_PERR_BIT]  = parity_flag;
        status_byte[STAT_EMPTY_BIT] = fifo_empty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata   <= '0;
            last_popped <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                ADDR_STATUS: bus_rdata <= status_byte;
                ADDR_DATA: begin
                    if (fifo_empty) begin
                        bus_rdata <= last_popped;
                    end else begin
                        bus_rdata   <= fifo_dout;
                        last_popped <= fifo_dout;
                    end
                end
                default: bus_rdata <= '0;
            endcase
        end
    end

    // Transmit launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_start <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_start <= wr_data;
            if (wr_data) tx_byte <= bus_wdata;
        end
    end

    sc_card_clk_div #(
        .DIV_W (DIV_W)
    ) u_clk_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_value (divisor_q),
        .reload    (wr_divisor),
        .card_clk  (card_clk)
    );

    sc_etu_loader #(
        .ETU_W     (ETU_W),
        .BUS_W     (BUS_W),
        .ETU_RESET (ETU_RESET)
    ) u_etu (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_etu),
        .wdata     (bus_wdata),
        .etu_value (etu_value)
    );

    sc_trigger_unit u_trigger (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_tx_pulse (cfg_q.trig_tx),
        .en_rx_pulse (cfg_q.trig_rx),
        .en_hold     (cfg_q.trig_hold),
        .tx_done     (tx_done),
        .rx_start    (rx_start),
        .tx_begin    (tx_start),
        .trigger     (trigger)
    );

    logic unused_full;
    assign unused_full = fifo_full;

endmodule

// File: rtl/sc_reader_checker.sv
`timescale 1ns/1ps
module sc_reader_checker #(
    parameter int FIFO_DEPTH = 16,
    parameter int ETU_W      = 11,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic             tx_start,
    input logic [7:0]       tx_byte,
    input logic             tx_done,
    input logic             rx_start,
    input logic             rx_valid,
    input logic             rx_parity_err,
    input logic [1:0]       parity_mode,
    input logic [ETU_W-1:0] etu_value,
    input logic             trigger,
    input logic             trig_tx_en,
    input logic             trig_rx_en,
    input logic [LVL_W-1:0] fifo_level,
    input logic             parity_flag
);

    assert_tx_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd5) |=> (tx_start && tx_byte == $past(bus_wdata)));

    assert_tx_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd5) |=> !tx_start);

    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1 && bus_wdata[0]) |=> (fifo_level == '0));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(FIFO_DEPTH));

    assert_parity_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_parity_err) |=> parity_flag);

    assert_parity_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rx_valid && rx_parity_err) && !(bus_wr && bus_addr == 3'd0 && !bus_wdata[1]))
        |=> $stable(parity_flag));

    assert_etu_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd4) |=> $stable(etu_value));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd2) |=> $stable(parity_mode));

    assert_tx_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && trig_tx_en) |=> trigger);

    assert_rx_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start && trig_rx_en) |=> trigger);

    assert_hold_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start && !tx_done && !trig_rx_en) |=> !trigger);

endmodule

bind sc_reader_regs sc_reader_checker #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .ETU_W      (ETU_W)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .tx_start      (tx_start),
    .tx_byte       (tx_byte),
    .tx_done       (tx_done),
    .rx_start      (rx_start),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err),
    .parity_mode   (parity_mode),
    .etu_value     (etu_value),
    .trigger       (trigger),
    .trig_tx_en    (cfg_q.trig_tx),
    .trig_rx_en    (cfg_q.trig_rx),
    .fifo_level    (fifo_level),
    .parity_flag   (parity_flag)
);

// File: tb/test_sc_reader_regs.sv
`timescale 1ns/1ps
module test_sc_reader_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tx_start;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b1;
    logic        tx_done = 1'b0;
    logic        rx_start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_parity_err = 1'b0;
    logic [1:0]  parity_mode;
    logic [10:0] etu_value;
    logic        card_clk;
    logic        trigger;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sc_reader_regs i_sc_reader_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .tx_start      (tx_start),
        .tx_byte       (tx_byte),
        .tx_ready      (tx_ready),
        .tx_done       (tx_done),
        .rx_start      (rx_start),
        .rx_valid      (rx_valid),
        .rx_byte       (rx_byte),
        .rx_parity_err (rx_parity_err),
        .parity_mode   (parity_mode),
        .etu_value     (etu_value),
        .card_clk      (card_clk),
        .trigger       (trigger)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Scoreboard for read data
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard", int'(bus_rdata), -1);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, t, int'(bus_rdata), int'(e));
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic read_expect(input logic [2:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b, input logic perr);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_byte = b; rx_parity_err = perr;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_parity_err = 1'b0;
    endtask

    task automatic pulse_tx_done();
        @(posedge clk); #1; tx_done = 1'b1;
        @(posedge clk); #1; tx_done = 1'b0;
    endtask

    task automatic pulse_rx_start();
        @(posedge clk); #1; rx_start = 1'b1;
        @(posedge clk); #1; rx_start = 1'b0;
    endtask

    task automatic card_period(output int p);
        logic prev;
        do begin prev = card_clk; @(negedge clk); end while (!(prev == 1'b0 && card_clk == 1'b1));
        p = 0;
        do begin prev = card_clk; @(negedge clk); p++; end while (!(prev == 1'b0 && card_clk == 1'b1));
    endtask

    initial begin
        int p;
        repeat (3) @(posedge clk);
        #1;
        // R1: values under reset
        chk(etu_value == 11'd371, "R1 etu reset", int'(etu_value), 371);
        chk(trigger == 1'b0 && tx_start == 1'b0, "R1 trigger/tx_start reset", int'(trigger), 0);
        chk(card_clk == 1'b0, "R1 card_clk reset", int'(card_clk), 0);
        chk(parity_mode == 2'd0, "R1 parity mode reset", int'(parity_mode), 0);
        rst_n = 1'b1;

        read_expect(3'd0, 8'h05, "R1 status after reset");
        tx_ready = 1'b0;
        read_expect(3'd0, 8'h04, "R2 status with transceiver busy");
        tx_ready = 1'b1;
        read_expect(3'd3, 8'h00, "R2 write-only address reads 0");

        // R5/R6: order and empty read
        rx_push(8'h11, 1'b0);
        rx_push(8'h22, 1'b0);
        rx_push(8'h33, 1'b0);
        read_expect(3'd5, 8'h11, "R5 first byte");
        read_expect(3'd5, 8'h22, "R6 second byte");
        read_expect(3'd5, 8'h33, "R5 third byte");
        read_expect(3'd5, 8'h33, "R6 empty read repeats last");
        read_expect(3'd0, 8'h05, "R6 empty read does not underflow");

        // R3: parity flag
        rx_push(8'h44, 1'b1);
        read_expect(3'd0, 8'h03, "R3 parity flag set");
        bus_write(3'd0, 8'h02);
        read_expect(3'd0, 8'h03, "R3 writing one keeps flag");
        bus_write(3'd0, 8'h00);
        read_expect(3'd0, 8'h01, "R3 writing zero clears flag");

        // R4: flush
        bus_write(3'd1, 8'h01);
        read_expect(3'd0, 8'h05, "R4 flush empties");
        read_expect(3'd5, 8'h33, "R4 flushed byte not returned");

        // R5: overflow
        for (int i = 0; i < 18; i++) rx_push(8'h80 + 8'(i), 1'b0);
        for (int i = 0; i < 16; i++) read_expect(3'd5, 8'h80 + 8'(i), "R5 full queue order");
        read_expect(3'd0, 8'h05, "R5 extra bytes dropped");

        // R4: flush and arrival in the same cycle
        rx_push(8'h55, 1'b0);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h01;
        rx_valid = 1'b1; rx_byte = 8'h77;
        @(posedge clk); #1;
        bus_wr = 1'b0; rx_valid = 1'b0;
        read_expect(3'd0, 8'h05, "R4 flush beats arrival");

        // R7: transmit launch
        bus_write(3'd5, 8'hA5);
        chk(tx_start == 1'b1 && tx_byte == 8'hA5, "R7 tx launch", int'(tx_byte), 8'hA5);
        @(posedge clk); #1;
        chk(tx_start == 1'b0, "R7 tx_start one cycle", int'(tx_start), 0);

        // R8: parity mode
        bus_write(3'd2, 8'h18);
        chk(parity_mode == 2'd3, "R8 parity mode 3", int'(parity_mode), 3);
        bus_write(3'd2, 8'h08);
        chk(parity_mode == 2'd1, "R8 parity mode 1", int'(parity_mode), 1);

        // R9: card clock
        bus_write(3'd3, 8'd2);
        card_period(p);
        chk(p == 6, "R9 period D=2", p, 6);
        bus_write(3'd3, 8'd0);
        card_period(p);
        chk(p == 2, "R9 period D=0", p, 2);

        // R10: ETU load
        bus_write(3'd4, 8'h05);
        chk(etu_value == 11'd371, "R10 unchanged after first write", int'(etu_value), 371);
        bus_write(3'd4, 8'hAB);
        chk(etu_value == 11'h5AB, "R10 loaded", int'(etu_value), 'h5AB);
        bus_write(3'd4, 8'h07);
        bus_write(3'd4, 8'hFF);
        chk(etu_value == 11'h7FF, "R10 loaded max", int'(etu_value), 'h7FF);

        // R11: transmit-end pulse
        bus_write(3'd2, 8'h00);
        pulse_tx_done();
        chk(trigger == 1'b0, "R11 disabled", int'(trigger), 0);
        bus_write(3'd2, 8'h01);
        pulse_tx_done();
        chk(trigger == 1'b1, "R11 pulse", int'(trigger), 1);
        @(posedge clk); #1;
        chk(trigger == 1'b0, "R11 pulse width", int'(trigger), 0);

        // R12: receive-start pulse
        bus_write(3'd2, 8'h02);
        pulse_rx_start();
        chk(trigger == 1'b1, "R12 pulse", int'(trigger), 1);
        @(posedge clk); #1;
        chk(trigger == 1'b0, "R12 pulse width", int'(trigger), 0);

        // R13: hold mode
        bus_write(3'd2, 8'h04);
        pulse_tx_done();
        chk(trigger == 1'b1, "R13 hold rises", int'(trigger), 1);
        repeat (3) @(posedge clk);
        #1;
        chk(trigger == 1'b1, "R13 hold stays", int'(trigger), 1);
        pulse_rx_start();
        chk(trigger == 1'b0, "R13 released by reception", int'(trigger), 0);
        pulse_tx_done();
        chk(trigger == 1'b1, "R13 hold rises again", int'(trigger), 1);
        bus_write(3'd5, 8'h3C);
        chk(trigger == 1'b1, "R13 held until tx begins", int'(trigger), 1);
        @(posedge clk); #1;
        chk(trigger == 1'b0, "R13 released by transmission", int'(trigger), 0);

        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule